// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block holds the fixed power-management event registers of a system controller and drives the level-sensitive system control interrupt (SCI). Hardware event inputs set status flags. These inputs are the power button, sleep button, real-time clock alarm, timer overflow, global-release, bus-master activity, wake, and a small bank of general-purpose event lines. Software reads the flags over a simple register port and acknowledges them by writing ones. An enable register masks which pending flags may raise the SCI.

The register port has a byte address, read and write strobes, lane byte enables, write data and combinational read data. The two 16-bit event registers accept only two-byte accesses. The two general-purpose event registers accept only single-byte accesses. An access of the wrong size is refused: nothing changes, the read returns zero, and an error flag pulses. The SCI is tracked by a two-state machine. `SCI_QUIET` goes to `SCI_ASSERTED` on transition RAISE, when some enabled event is pending. `SCI_ASSERTED` returns to `SCI_QUIET` on transition DROP, when no enabled event remains pending. Otherwise each state holds.

Top module: `pm_event_bank`

## Requirements
- R1: Event inputs set status bits at these fixed positions: timer 0, bus master 4, global 5, power button 8, sleep button 9, RTC 10, wake 15. The general-purpose raise input bit i sets status bit i. Each set is visible on the cycle after the input is sampled.
- R2: A two-byte write to the event status register (byte offset 0) clears each bit written as 1 among wake, RTC, sleep button, power button and bus master. The timer and global bits and all other bits ignore such writes.
- R3: A two-byte write to the event enable register (byte offset 2) keeps only the RTC (bit 10), power button (bit 8) and global (bit 5) bits. All other enable bits read back as 0.
- R4: The SCI output is high when timer, global, power button, sleep button or RTC has both status and enable set, or when general-purpose status AND enable is nonzero. It follows that condition one cycle after the register change and stays high until the condition clears.
- R5: The event registers accept only byte enables 4'b0011, and the general-purpose status (offset 4) and enable (offset 5) registers accept only 4'b0001. An access with any other byte enables changes no register and reads 0.
- R6: General-purpose status is write-1-to-clear, limited to the valid mask (default 8'h0F). A write to general-purpose enable stores only the valid-mask bits.
- R7: A power-button event sets status bit 8. If bit 8 is already set, the bit stays set.
- R8: After reset every status and enable register reads 0, and SCI and error are low.
- R9: A general-purpose raise on a bit outside the valid mask leaves the status unchanged.
- R10: When a hardware set and a software clear hit the same status bit in one cycle, the bit ends up set.
- R11: A wrong-size access to a mapped register raises the error output for exactly the following cycle. Correctly sized accesses never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | DATA_W/8 | Lane byte enables, lane 0 = bits 7:0 |
| reg_wdata | input | DATA_W | Write data, low-aligned |
| reg_rdata | output | DATA_W | Read data, zero unless a valid read |
| reg_err | output | 1 | One-cycle pulse after a wrong-size access |
| evt_tmr | input | 1 | Timer overflow event |
| evt_bm | input | 1 | Bus-master activity event |
| evt_gbl | input | 1 | Global-release event |
| evt_pwrbtn | input | 1 | Power-button event |
| evt_slpbtn | input | 1 | Sleep-button event |
| evt_rtc | input | 1 | RTC alarm event |
| evt_wak | input | 1 | Wake event |
| gpe_raise | input | GPE_W | General-purpose event raise lines |
| sci | output | 1 | Level system control interrupt |

## Verification
The assertions take for granted that the strobes, address, byte enables and event inputs are stable around each rising edge. They also assume that a read and a write are never presented together, so each access has a single meaning. The bench changes every input only at the falling edge. It raises at most one strobe per cycle and drops it before the next access. Event pulses are one cycle wide, except in the tests that hold them on purpose to collide with a clearing write.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    // Status / enable bit positions (decoded by software)
    localparam int BIT_TMR    = 0;
    localparam int BIT_BM     = 4;
    localparam int BIT_GBL    = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_SLPBTN = 9;
    localparam int BIT_RTC    = 10;
    localparam int BIT_WAK    = 15;

    localparam logic [15:0] STS_W1C_MASK =
        (16'd1 << BIT_WAK) | (16'd1 << BIT_RTC) | (16'd1 << BIT_SLPBTN) |
        (16'd1 << BIT_PWRBTN) | (16'd1 << BIT_BM);
    localparam logic [15:0] EN_STORE_MASK =
        (16'd1 << BIT_RTC) | (16'd1 << BIT_PWRBTN) | (16'd1 << BIT_GBL);
    localparam logic [15:0] SCI_PAIR_MASK =
        (16'd1 << BIT_TMR) | (16'd1 << BIT_GBL) | (16'd1 << BIT_PWRBTN) |
        (16'd1 << BIT_SLPBTN) | (16'd1 << BIT_RTC);

    // Byte offsets; enable sits two bytes above status
    localparam int OFS_EVT_STS = 0;
    localparam int OFS_EVT_EN  = OFS_EVT_STS + 2;
    localparam int OFS_GPE_STS = 4;
    localparam int OFS_GPE_EN  = 5;

    typedef struct packed {
        logic evt_sts;
        logic evt_en;
        logic gpe_sts;
        logic gpe_en;
    } reg_sel_t;

    typedef enum logic [0:0] {
        SCI_QUIET    = 1'b0,
        SCI_ASSERTED = 1'b1
    } sci_state_t;

endpackage

// File: rtl/pm_access_decode.sv
module pm_access_decode
    import pm_event_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd,
    input  logic                wr,
    input  logic [DATA_W/8-1:0] be,
    output reg_sel_t            wr_sel,
    output reg_sel_t            rd_sel,
    output logic                bad_size
);
    localparam int BE_W = DATA_W / 8;
    localparam logic [BE_W-1:0] BE_HALF = BE_W'(2'b11);
    localparam logic [BE_W-1:0] BE_BYTE = BE_W'(1'b1);

    reg_sel_t hit;
    logic     half_ok;
    logic     byte_ok;
    logic     any_acc;

    always_comb begin
        hit.evt_sts = (addr == ADDR_W'(OFS_EVT_STS));
        hit.evt_en  = (addr == ADDR_W'(OFS_EVT_EN));
        hit.gpe_sts = (addr == ADDR_W'(OFS_GPE_STS));
        hit.gpe_en  = (addr == ADDR_W'(OFS_GPE_EN));
        half_ok     = (be == BE_HALF);
        byte_ok     = (be == BE_BYTE);
        any_acc     = rd | wr;

        wr_sel.evt_sts = wr & hit.evt_sts & half_ok;
        wr_sel.evt_en  = wr & hit.evt_en  & half_ok;
        wr_sel.gpe_sts = wr & hit.gpe_sts & byte_ok;
        wr_sel.gpe_en  = wr & hit.gpe_en  & byte_ok;

        rd_sel.evt_sts = rd & hit.evt_sts & half_ok;
        rd_sel.evt_en  = rd & hit.evt_en  & half_ok;
        rd_sel.gpe_sts = rd & hit.gpe_sts & byte_ok;
        rd_sel.gpe_en  = rd & hit.gpe_en  & byte_ok;

        bad_size = any_acc &
                   (((hit.evt_sts | hit.evt_en) & ~half_ok) |
                    ((hit.gpe_sts | hit.gpe_en) & ~byte_ok));
    end
endmodule

// File: rtl/pm1_event_regs.sv
module pm1_event_regs
    import pm_event_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sts,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic [15:0] set_vec,
    output logic [15:0] sts,
    output logic [15:0] en
);
    logic [15:0] clr_vec;

    always_comb begin
        clr_vec = wr_sts ? (wdata & STS_W1C_MASK) : 16'h0000;
    end

    // Hardware set is applied after the clear, so it wins a collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= 16'h0000;
        end else begin
            sts <= (sts & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 16'h0000;
        end else if (wr_en) begin
            en <= wdata & EN_STORE_MASK;
        end
    end
endmodule

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = GPE_W'(8'h0F)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [GPE_W-1:0] wdata,
    input  logic [GPE_W-1:0] raise,
    output logic [GPE_W-1:0] sts,
    output logic [GPE_W-1:0] en
);
    for (genvar i = 0; i < GPE_W; i++) begin : g_bit
        if (GPE_VALID[i]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sts[i] <= 1'b0;
                end else begin
                    sts[i] <= (sts[i] & ~(wr_sts & wdata[i])) | raise[i];
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en[i] <= 1'b0;
                end else if (wr_en) begin
                    en[i] <= wdata[i];
                end
            end
        end else begin : g_tied
            assign sts[i] = 1'b0;
            assign en[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/sci_level_fsm.sv
module sci_level_fsm
    import pm_event_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic need,
    output logic sci
);
    sci_state_t state;
    sci_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SCI_QUIET:    if (need)  state_nx = SCI_ASSERTED; // RAISE
            SCI_ASSERTED: if (!need) state_nx = SCI_QUIET;    // DROP
            default:      state_nx = SCI_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SCI_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        sci = (state == SCI_ASSERTED);
    end
endmodule

// File: rtl/pm_event_bank.sv
module pm_event_bank
    import pm_event_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 32,
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = GPE_W'(8'h0F)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_err,
    input  logic                evt_tmr,
    input  logic                evt_bm,
    input  logic                evt_gbl,
    input  logic                evt_pwrbtn,
    input  logic                evt_slpbtn,
    input  logic                evt_rtc,
    input  logic                evt_wak,
    input  logic [GPE_W-1:0]    gpe_raise,
    output logic                sci
);
    reg_sel_t         wr_sel;
    reg_sel_t         rd_sel;
    logic             bad_size;
    logic [15:0]      pm1_set;
    logic [15:0]      pm1_sts;
    logic [15:0]      pm1_en;
    logic [GPE_W-1:0] gpe_sts;
    logic [GPE_W-1:0] gpe_en;
    logic [GPE_W-1:0] gpe_set;
    logic             sci_need;

    pm_access_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr     (reg_addr),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .be       (reg_be),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel),
        .bad_size (bad_size)
    );

    always_comb begin
        pm1_set = 16'h0000;
        pm1_set[BIT_TMR]    = evt_tmr;
        pm1_set[BIT_BM]     = evt_bm;
        pm1_set[BIT_GBL]    = evt_gbl;
        pm1_set[BIT_PWRBTN] = evt_pwrbtn;
        pm1_set[BIT_SLPBTN] = evt_slpbtn;
        pm1_set[BIT_RTC]    = evt_rtc;
        pm1_set[BIT_WAK]    = evt_wak;
        gpe_set = gpe_raise & GPE_VALID;
    end

    pm1_event_regs u_pm1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sts  (wr_sel.evt_sts),
        .wr_en   (wr_sel.evt_en),
        .wdata   (reg_wdata[15:0]),
        .set_vec (pm1_set),
        .sts     (pm1_sts),
        .en      (pm1_en)
    );

    gpe_event_regs #(.GPE_W(GPE_W), .GPE_VALID(GPE_VALID)) u_gpe (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sts (wr_sel.gpe_sts),
        .wr_en  (wr_sel.gpe_en),
        .wdata  (reg_wdata[GPE_W-1:0]),
        .raise  (gpe_set),
        .sts    (gpe_sts),
        .en     (gpe_en)
    );

    always_comb begin
        sci_need = (|(pm1_sts & pm1_en & SCI_PAIR_MASK)) | (|(gpe_sts & gpe_en));
    end

    sci_level_fsm u_sci (
        .clk   (clk),
        .rst_n (rst_n),
        .need  (sci_need),
        .sci   (sci)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd_sel.evt_sts) reg_rdata = DATA_W'(pm1_sts);
        if (rd_sel.evt_en)  reg_rdata = DATA_W'(pm1_en);
        if (rd_sel.gpe_sts) reg_rdata = DATA_W'(gpe_sts);
        if (rd_sel.gpe_en)  reg_rdata = DATA_W'(gpe_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_err <= 1'b0;
        end else begin
            reg_err <= bad_size;
        end
    end
endmodule

// File: rtl/pm_event_bank_chk.sv
module pm_event_bank_chk #(
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 32,
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = GPE_W'(8'h0F)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_rd,
    input logic                reg_wr,
    input logic [DATA_W/8-1:0] reg_be,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                reg_err,
    input logic                evt_pwrbtn,
    input logic [15:0]         pm1_sts,
    input logic [15:0]         pm1_en,
    input logic [GPE_W-1:0]    gpe_sts,
    input logic [GPE_W-1:0]    gpe_en,
    input logic                sci
);
    localparam logic [15:0] PAIRS = 16'h0721;
    localparam logic [DATA_W/8-1:0] BE_HALF = (DATA_W/8)'(2'b11);
    localparam logic [DATA_W/8-1:0] BE_BYTE = (DATA_W/8)'(1'b1);

    logic pending;
    always_comb pending = (|(pm1_sts & pm1_en & PAIRS)) | (|(gpe_sts & gpe_en));

    a_r4_sci_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        sci == $past(pending));

    a_r7_pwrbtn_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pwrbtn |=> pm1_sts[8]);

    a_r5_en_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(2) && reg_be != BE_HALF) |=> $stable(pm1_en));

    a_r6_gpe_en_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(5) && reg_be == BE_BYTE)
        |=> gpe_en == ($past(reg_wdata[GPE_W-1:0]) & GPE_VALID));

    a_r11_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_rd || reg_wr));
endmodule

bind pm_event_bank pm_event_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPE_W(GPE_W), .GPE_VALID(GPE_VALID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_be     (reg_be),
    .reg_wdata  (reg_wdata),
    .reg_err    (reg_err),
    .evt_pwrbtn (evt_pwrbtn),
    .pm1_sts    (pm1_sts),
    .pm1_en     (pm1_en),
    .gpe_sts    (gpe_sts),
    .gpe_en     (gpe_en),
    .sci        (sci)
);

// File: tb/pm_event_bank_bench.sv
`timescale 1ns/1ps
module pm_event_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        evt_tmr = 0, evt_bm = 0, evt_gbl = 0, evt_pwrbtn = 0;
    logic        evt_slpbtn = 0, evt_rtc = 0, evt_wak = 0;
    logic [7:0]  gpe_raise = '0;
    logic        sci;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pm_event_bank u_pm_event_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .evt_tmr(evt_tmr),
        .evt_bm(evt_bm), .evt_gbl(evt_gbl), .evt_pwrbtn(evt_pwrbtn),
        .evt_slpbtn(evt_slpbtn), .evt_rtc(evt_rtc), .evt_wak(evt_wak),
        .gpe_raise(gpe_raise), .sci(sci)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
        logic        exp_err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        vec_t'{1'b1, 8'd2, 4'b0011, 32'h0000_FFFF, 32'h0, 1'b0}, // R3 write all ones
        vec_t'{1'b0, 8'd2, 4'b0011, 32'h0, 32'h0000_0520, 1'b0}, // R3 readback
        vec_t'{1'b1, 8'd5, 4'b0001, 32'h0000_00FF, 32'h0, 1'b0}, // R6 gpe enable
        vec_t'{1'b0, 8'd5, 4'b0001, 32'h0, 32'h0000_000F, 1'b0}, // R6 readback
        vec_t'{1'b1, 8'd2, 4'b0001, 32'h0, 32'h0, 1'b1},         // R5 byte write to 16-bit
        vec_t'{1'b0, 8'd2, 4'b0011, 32'h0, 32'h0000_0520, 1'b0}, // R5 unchanged
        vec_t'{1'b1, 8'd5, 4'b0011, 32'h0, 32'h0, 1'b1},         // R5 half write to byte reg
        vec_t'{1'b0, 8'd5, 4'b0001, 32'h0, 32'h0000_000F, 1'b0}, // R5 unchanged
        vec_t'{1'b0, 8'd0, 4'b0001, 32'h0, 32'h0, 1'b1},         // R5 R11 wrong-size read
        vec_t'{1'b0, 8'd0, 4'b0011, 32'h0, 32'h0, 1'b0},         // R2 status empty
        vec_t'{1'b1, 8'd2, 4'b0011, 32'h0, 32'h0, 1'b0},         // R3 clear enables
        vec_t'{1'b0, 8'd2, 4'b0011, 32'h0, 32'h0, 1'b0}          // R3 readback zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        check("R8 sci", {31'b0, sci}, 32'h0);
        check("R8 err", {31'b0, reg_err}, 32'h0);
        rd_reg(8'd0, 4'b0011, r); check("R8 evt status", r, 32'h0);
        rd_reg(8'd2, 4'b0011, r); check("R8 evt enable", r, 32'h0);
        rd_reg(8'd4, 4'b0001, r); check("R8 gpe status", r, 32'h0);
        rd_reg(8'd5, 4'b0001, r); check("R8 gpe enable", r, 32'h0);

        // Vector table
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            reg_addr = VECS[i].addr; reg_be = VECS[i].be; reg_wdata = VECS[i].data;
            reg_wr = VECS[i].wr; reg_rd = ~VECS[i].wr;
            #1 r = reg_rdata;
            @(negedge clk);
            if (!VECS[i].wr) check("R3 R5 R6 vector read", r, VECS[i].exp);
            check("R5 R11 vector err", {31'b0, reg_err}, {31'b0, VECS[i].exp_err});
            reg_wr = 1'b0; reg_rd = 1'b0;
        end
        @(negedge clk);
        check("R11 err one cycle", {31'b0, reg_err}, 32'h0);

        // R7 R4 power button with enable
        wr_reg(8'd2, 4'b0011, 32'h0100);
        @(negedge clk); evt_pwrbtn = 1'b1; @(negedge clk); evt_pwrbtn = 1'b0;
        rd_reg(8'd0, 4'b0011, r); check("R7 R1 pwrbtn bit 8", r, 32'h0100);
        check("R4 sci raised", {31'b0, sci}, 32'h1);
        @(negedge clk); evt_pwrbtn = 1'b1; @(negedge clk); evt_pwrbtn = 1'b0;
        rd_reg(8'd0, 4'b0011, r); check("R7 repeat keeps set", r, 32'h0100);
        wr_reg(8'd0, 4'b0011, 32'h0100);
        @(negedge clk);
        check("R4 sci held until clear lands", {31'b0, sci}, 32'h0);
        rd_reg(8'd0, 4'b0011, r); check("R2 pwrbtn cleared", r, 32'h0);

        // R1 R2 sticky timer and global, clearable others
        @(negedge clk);
        {evt_tmr, evt_bm, evt_gbl, evt_slpbtn, evt_rtc, evt_wak} = 6'h3F;
        @(negedge clk);
        {evt_tmr, evt_bm, evt_gbl, evt_slpbtn, evt_rtc, evt_wak} = 6'h00;
        rd_reg(8'd0, 4'b0011, r); check("R1 all positions", r, 32'h8631);
        wr_reg(8'd0, 4'b0011, 32'hFFFF);
        rd_reg(8'd0, 4'b0011, r); check("R2 timer global survive", r, 32'h0021);
        check("R4 timer not enableable, pwrbtn en only", {31'b0, sci}, 32'h0);
        wr_reg(8'd2, 4'b0011, 32'h0020);
        @(negedge clk);
        check("R4 global pair raises sci", {31'b0, sci}, 32'h1);
        wr_reg(8'd2, 4'b0011, 32'h0);
        @(negedge clk);
        check("R4 sci drops with enable", {31'b0, sci}, 32'h0);

        // R6 R9 general-purpose events (enable 0x0F from vectors)
        @(negedge clk); gpe_raise = 8'h22; @(negedge clk); gpe_raise = 8'h00;
        rd_reg(8'd4, 4'b0001, r); check("R9 invalid raise ignored", r, 32'h02);
        check("R4 gpe raises sci", {31'b0, sci}, 32'h1);
        wr_reg(8'd4, 4'b0001, 32'hFF);
        rd_reg(8'd4, 4'b0001, r); check("R6 gpe w1c", r, 32'h0);
        check("R4 gpe sci cleared", {31'b0, sci}, 32'h0);

        // R10 set wins on collision
        @(negedge clk);
        gpe_raise = 8'h04; evt_rtc = 1'b1;
        reg_addr = 8'd4; reg_be = 4'b0001; reg_wdata = 32'h04; reg_wr = 1'b1;
        @(negedge clk);
        reg_addr = 8'd0; reg_be = 4'b0011; reg_wdata = 32'h0400;
        @(negedge clk);
        reg_wr = 1'b0; gpe_raise = 8'h00; evt_rtc = 1'b0;
        rd_reg(8'd4, 4'b0001, r); check("R10 gpe set wins", r, 32'h04);
        rd_reg(8'd0, 4'b0011, r); check("R10 rtc set wins", r, 32'h0421);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule